// File: doc/BRIEF.md
# MESI Snoop Coherency Controller

This block holds the tags and the four-state coherency state for a write-back, set-associative data cache. The tag store has two independent lookup ports. The processor side uses one port for reads, write-ownership checks and line fills. The bus snooper uses the other port to check a snooped address in the same cycle. Each snoop receives a response one cycle later. The response is one of four: no action, the line is kept as shared, the line was invalidated, or the address must be retried.

When a snoop hits a modified line, the block answers with a retry and starts a push-out of that line on a valid/ready write-back port. The processor side is held off only while that push-out is pending. After the push-out completes, the line is downgraded or dropped according to the kind of snoop. A fill that replaces a modified line reports the victim's line address so that the caller can write it back. When a processor state update and a snoop action land on the same line in the same cycle, the snoop action is applied and the processor request is returned for replay.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. Every processor read misses, and `cpu_stall`, `wb_valid`, `cpu_done` and `snp_resp_valid` are all low.
- R2: An address is split into a tag in bits [31:12], a set index in bits [11:5] and a byte offset in bits [4:0]. The offset has no effect on a lookup.
- R3: Processor op codes are 0 = read, 1 = write and 2 = fill. State codes are 0 = invalid, 1 = shared, 2 = exclusive and 3 = modified. A read reports hit and the current state. A write that hits an exclusive or modified line makes it modified and reports a hit. A write to a shared or absent line reports no hit and changes nothing. Results appear with `cpu_done` in the cycle after the request.
- R4: A fill writes the tag into way `cpu_way` of the set, with state exclusive when `cpu_excl` is 1 and shared otherwise. If that way held a modified line, `cpu_evict` pulses and `cpu_evict_addr` gives that line's address with a zero offset.
- R5: Snoop response codes are 0 = none, 1 = shared, 2 = invalidated and 3 = retry. A snooped read (`snp_kill` = 0) that hits an exclusive or shared line leaves it shared and answers 1. A snoop that misses answers 0.
- R6: A snooped write or read-for-ownership (`snp_kill` = 1) that hits an exclusive or shared line invalidates it and answers 2.
- R7: A snoop that hits a modified line answers 3. One cycle later `wb_valid` rises with that line's address, and both are held until `wb_ready` is high.
- R8: At the write-back handshake the pushed line becomes shared if the snoop was a read, or invalid if it was a write. `wb_valid` and `cpu_stall` fall.
- R9: A snoop that hits a modified line while a push-out is pending answers 3 again and does not start a second push-out.
- R10: While `cpu_stall` is high, processor requests are ignored and give no `cpu_done`. Otherwise every request gets `cpu_done` or `cpu_replay` in the next cycle.
- R11: If a processor update (a write hit or a fill) and a snoop state change or push-out start target the same set and way in one cycle, the snoop action is applied. The processor update is dropped and `cpu_replay` pulses instead of `cpu_done`.
- R12: A processor access and a snoop to different lines in the same cycle are both fully serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 read, 1 write, 2 fill |
| cpu_addr | input | 32 | Physical address of the request |
| cpu_way | input | 2 | Target way for a fill |
| cpu_excl | input | 1 | Fill installs exclusive (1) or shared (0) |
| cpu_stall | output | 1 | Push-out pending; requests are not taken |
| cpu_done | output | 1 | Request completed last cycle |
| cpu_replay | output | 1 | Request lost to a snoop; reissue it |
| cpu_hit | output | 1 | Request hit (always 1 for a completed fill) |
| cpu_state | output | 2 | Line state after the request |
| cpu_evict | output | 1 | Fill displaced a modified line |
| cpu_evict_addr | output | 32 | Line address of the displaced line |
| snp_valid | input | 1 | Snooped bus address present |
| snp_kill | input | 1 | Snoop is a write or read-for-ownership |
| snp_addr | input | 32 | Snooped physical address |
| snp_resp_valid | output | 1 | Snoop response valid |
| snp_resp | output | 2 | 0 none, 1 shared, 2 invalidated, 3 retry |
| wb_valid | output | 1 | Push-out request to write-back port |
| wb_addr | output | 32 | Line address being pushed out |
| wb_ready | input | 1 | Write-back port accepts the push-out |

## Verification
The processor results and the snoop response are each one register past the edge that samples the request. The bench drives inputs on the falling edge and reads both results at the next falling edge. `wb_valid` rises one edge after the retried snoop is sampled and can therefore be read in the same check as the retry response. The pushed line's new state and the fall of `cpu_stall` take effect at the handshake edge, so the bench reads them at the falling edge after that handshake and confirms the state with a fresh read one cycle later. The table rows each take one cycle. The push-out tests step cycle by cycle with `wb_ready` held low or raised at chosen points.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_FILL = 2'd2} cpu_op_t;
  typedef enum logic [1:0] {SR_NONE = 2'd0, SR_SHARED = 2'd1, SR_INVAL = 2'd2, SR_RETRY = 2'd3} snp_resp_t;

  typedef struct packed {
    snp_resp_t resp;
    logic      upd;
    mesi_t     nst;
    logic      push;
  } snp_dec_t;

  // Snoop outcome for one looked-up line.
  function automatic snp_dec_t snoop_decide(input logic hit, input mesi_t st,
                                            input logic kill, input logic busy);
    snp_dec_t d;
    d.resp = SR_NONE;
    d.upd  = 1'b0;
    d.nst  = st;
    d.push = 1'b0;
    if (hit) begin
      unique case (st)
        ST_M: begin
          d.resp = SR_RETRY;
          d.push = !busy;
        end
        ST_E, ST_S: begin
          if (kill) begin
            d.resp = SR_INVAL;
            d.upd  = 1'b1;
            d.nst  = ST_I;
          end else begin
            d.resp = SR_SHARED;
            d.upd  = (st == ST_E);
            d.nst  = ST_S;
          end
        end
        default: d.resp = SR_NONE;
      endcase
    end
    return d;
  endfunction

  // State a pushed-out line ends in.
  function automatic mesi_t pushout_final(input logic kill);
    return kill ? ST_I : ST_S;
  endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int NPORT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   lk_idx   [NPORT],
  input  logic [TAG_W-1:0]          lk_tag   [NPORT],
  output logic                      lk_hit   [NPORT],
  output logic [$clog2(WAYS)-1:0]   lk_way   [NPORT],
  output mesi_t                     lk_state [NPORT],
  input  logic [$clog2(WAYS)-1:0]   v_way,
  output logic [TAG_W-1:0]          v_tag,
  output mesi_t                     v_state,
  input  logic                      cw_en,
  input  logic [$clog2(SETS)-1:0]   cw_idx,
  input  logic [$clog2(WAYS)-1:0]   cw_way,
  input  logic                      cw_tag_en,
  input  logic [TAG_W-1:0]          cw_tag,
  input  mesi_t                     cw_state,
  input  logic                      pw_en,
  input  logic [$clog2(SETS)-1:0]   pw_idx,
  input  logic [$clog2(WAYS)-1:0]   pw_way,
  input  mesi_t                     pw_state,
  input  logic                      sw_en,
  input  logic [$clog2(SETS)-1:0]   sw_idx,
  input  logic [$clog2(WAYS)-1:0]   sw_way,
  input  mesi_t                     sw_state
);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  mesi_t            st_q  [SETS][WAYS];

  // Independent lookup ports, one per requester.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      lk_hit[p]   = 1'b0;
      lk_way[p]   = '0;
      lk_state[p] = ST_I;
      for (int w = 0; w < WAYS; w++) begin
        if (st_q[lk_idx[p]][w] != ST_I && tag_q[lk_idx[p]][w] == lk_tag[p]) begin
          lk_hit[p]   = 1'b1;
          lk_way[p]   = WAY_W'(w);
          lk_state[p] = st_q[lk_idx[p]][w];
        end
      end
    end
  end

  assign v_tag   = tag_q[lk_idx[0]][v_way];
  assign v_state = st_q[lk_idx[0]][v_way];

  always_ff @(posedge clk) begin
    if (cw_en && cw_tag_en) tag_q[cw_idx][cw_way] <= cw_tag;
  end

  // Later writes take priority: processor, then push-out, then snoop.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          st_q[s][w] <= ST_I;
    end else begin
      if (cw_en) st_q[cw_idx][cw_way] <= cw_state;
      if (pw_en) st_q[pw_idx][pw_way] <= pw_state;
      if (sw_en) st_q[sw_idx][sw_way] <= sw_state;
    end
  end

endmodule

// File: rtl/mesi_pushout.sv
module mesi_pushout
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [WAY_W-1:0]  start_way,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_kill,
  input  logic              wb_ready,
  output logic              busy,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              done,
  output logic [IDX_W-1:0]  done_idx,
  output logic [WAY_W-1:0]  done_way,
  output mesi_t             done_state
);
  logic kill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      kill_q   <= 1'b0;
      wb_addr  <= '0;
      done_idx <= '0;
      done_way <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      kill_q   <= start_kill;
      wb_addr  <= start_addr;
      done_idx <= start_idx;
      done_way <= start_way;
    end else if (busy && wb_ready) begin
      busy <= 1'b0;
    end
  end

  assign wb_valid   = busy;
  assign done       = busy && wb_ready;
  assign done_state = pushout_final(kill_q);

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wb_ready |=> wb_valid && $stable(wb_addr));

  // R9
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      snp_valid,
  input  logic      snp_kill,
  input  logic      hit,
  input  mesi_t     hit_state,
  input  logic      busy,
  output logic      upd_en,
  output mesi_t     upd_state,
  output logic      push_start,
  output logic      touch,
  output logic      resp_valid,
  output snp_resp_t resp
);
  snp_dec_t dec;

  assign dec        = snoop_decide(snp_valid && hit, hit_state, snp_kill, busy);
  assign upd_en     = dec.upd;
  assign upd_state  = dec.nst;
  assign push_start = dec.push;
  assign touch      = dec.upd || dec.push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp       <= SR_NONE;
    end else begin
      resp_valid <= snp_valid;
      resp       <= snp_valid ? dec.resp : SR_NONE;
    end
  end

  // R9
  retry_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && hit && hit_state == ST_M && busy |=> resp_valid && resp == SR_RETRY);

  // R6
  inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_kill && hit && (hit_state == ST_E || hit_state == ST_S)
    |=> resp == SR_INVAL);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_valid,
  input  logic [1:0]                cpu_op,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [$clog2(WAYS)-1:0]   cpu_way,
  input  logic                      cpu_excl,
  output logic                      cpu_stall,
  output logic                      cpu_done,
  output logic                      cpu_replay,
  output logic                      cpu_hit,
  output logic [1:0]                cpu_state,
  output logic                      cpu_evict,
  output logic [ADDR_W-1:0]         cpu_evict_addr,
  input  logic                      snp_valid,
  input  logic                      snp_kill,
  input  logic [ADDR_W-1:0]         snp_addr,
  output logic                      snp_resp_valid,
  output logic [1:0]                snp_resp,
  output logic                      wb_valid,
  output logic [ADDR_W-1:0]         wb_addr,
  input  logic                      wb_ready
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_of(input logic [TAG_W-1:0] t,
                                                input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  // Lookup ports: 0 = processor, 1 = snoop.
  logic [IDX_W-1:0] lk_idx   [2];
  logic [TAG_W-1:0] lk_tag   [2];
  logic             lk_hit   [2];
  logic [WAY_W-1:0] lk_way   [2];
  mesi_t            lk_state [2];
  logic [TAG_W-1:0] v_tag;
  mesi_t            v_state;

  logic              busy, po_done;
  logic [IDX_W-1:0]  po_idx;
  logic [WAY_W-1:0]  po_way;
  mesi_t             po_state;

  logic              s_upd_en, s_push, s_touch, s_resp_valid;
  mesi_t             s_upd_state;
  snp_resp_t         s_resp;

  // Processor-side decision.
  logic              c_upd, c_tag_en, c_hit, c_evict;
  logic [WAY_W-1:0]  c_way;
  mesi_t             c_new, c_rep;
  logic              cpu_acc, conflict, cw_en;
  logic              unused_off;

  assign unused_off = ^{cpu_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  assign lk_idx[0] = idx_of(cpu_addr);
  assign lk_tag[0] = tag_of(cpu_addr);
  assign lk_idx[1] = idx_of(snp_addr);
  assign lk_tag[1] = tag_of(snp_addr);

  always_comb begin
    c_upd    = 1'b0;
    c_tag_en = 1'b0;
    c_way    = lk_way[0];
    c_new    = ST_I;
    c_hit    = lk_hit[0];
    c_rep    = lk_hit[0] ? lk_state[0] : ST_I;
    c_evict  = 1'b0;
    unique case (cpu_op_t'(cpu_op))
      OP_WRITE: begin
        if (lk_hit[0] && (lk_state[0] == ST_E || lk_state[0] == ST_M)) begin
          c_upd = 1'b1;
          c_new = ST_M;
          c_rep = ST_M;
        end else begin
          c_hit = 1'b0;
        end
      end
      OP_FILL: begin
        c_upd    = 1'b1;
        c_tag_en = 1'b1;
        c_way    = cpu_way;
        c_new    = cpu_excl ? ST_E : ST_S;
        c_hit    = 1'b1;
        c_rep    = c_new;
        c_evict  = (v_state == ST_M);
      end
      default: ;
    endcase
  end

  assign cpu_acc   = cpu_valid && !busy;
  assign conflict  = cpu_acc && c_upd && s_touch &&
                     (lk_idx[0] == lk_idx[1]) && (c_way == lk_way[1]);
  assign cw_en     = cpu_acc && c_upd && !conflict;
  assign cpu_stall = busy;

  mesi_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .NPORT(2)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (lk_idx),
    .lk_tag   (lk_tag),
    .lk_hit   (lk_hit),
    .lk_way   (lk_way),
    .lk_state (lk_state),
    .v_way    (cpu_way),
    .v_tag    (v_tag),
    .v_state  (v_state),
    .cw_en    (cw_en),
    .cw_idx   (lk_idx[0]),
    .cw_way   (c_way),
    .cw_tag_en(c_tag_en),
    .cw_tag   (lk_tag[0]),
    .cw_state (c_new),
    .pw_en    (po_done),
    .pw_idx   (po_idx),
    .pw_way   (po_way),
    .pw_state (po_state),
    .sw_en    (s_upd_en),
    .sw_idx   (lk_idx[1]),
    .sw_way   (lk_way[1]),
    .sw_state (s_upd_state)
  );

  mesi_snoop_unit u_snoop (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_valid (snp_valid),
    .snp_kill  (snp_kill),
    .hit       (lk_hit[1]),
    .hit_state (lk_state[1]),
    .busy      (busy),
    .upd_en    (s_upd_en),
    .upd_state (s_upd_state),
    .push_start(s_push),
    .touch     (s_touch),
    .resp_valid(s_resp_valid),
    .resp      (s_resp)
  );

  mesi_pushout #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_push (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (s_push),
    .start_idx (lk_idx[1]),
    .start_way (lk_way[1]),
    .start_addr(line_of(lk_tag[1], lk_idx[1])),
    .start_kill(snp_kill),
    .wb_ready  (wb_ready),
    .busy      (busy),
    .wb_valid  (wb_valid),
    .wb_addr   (wb_addr),
    .done      (po_done),
    .done_idx  (po_idx),
    .done_way  (po_way),
    .done_state(po_state)
  );

  assign snp_resp_valid = s_resp_valid;
  assign snp_resp       = s_resp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_done       <= 1'b0;
      cpu_replay     <= 1'b0;
      cpu_hit        <= 1'b0;
      cpu_state      <= ST_I;
      cpu_evict      <= 1'b0;
      cpu_evict_addr <= '0;
    end else begin
      cpu_done       <= cpu_acc && !conflict;
      cpu_replay     <= conflict;
      cpu_hit        <= cpu_acc && !conflict && c_hit;
      cpu_state      <= (cpu_acc && !conflict) ? c_rep : ST_I;
      cpu_evict      <= cpu_acc && !conflict && c_evict;
      cpu_evict_addr <= line_of(v_tag, lk_idx[0]);
    end
  end

  // R10
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_stall |=> !cpu_done && !cpu_replay);

  // R10
  serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_stall |=> cpu_done || cpu_replay);

  // R7
  retry_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> snp_resp_valid && snp_resp == SR_RETRY);

  // R11
  replay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_replay |-> $past(snp_valid));

  // R11
  replay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_done, cpu_replay}));

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_excl, snp_valid, snp_kill, wb_ready;
  logic [1:0]  cpu_op, cpu_way;
  logic [31:0] cpu_addr, snp_addr;
  logic        cpu_stall, cpu_done, cpu_replay, cpu_hit, cpu_evict;
  logic [1:0]  cpu_state, snp_resp;
  logic [31:0] cpu_evict_addr, wb_addr;
  logic        snp_resp_valid, wb_valid;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mesi_snoop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_way(cpu_way), .cpu_excl(cpu_excl),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_replay(cpu_replay),
    .cpu_hit(cpu_hit), .cpu_state(cpu_state), .cpu_evict(cpu_evict),
    .cpu_evict_addr(cpu_evict_addr),
    .snp_valid(snp_valid), .snp_kill(snp_kill), .snp_addr(snp_addr),
    .snp_resp_valid(snp_resp_valid), .snp_resp(snp_resp),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready)
  );

  // Bench-side address builder: tag | set | offset.
  function automatic logic [31:0] mk(input int t, input int s, input int o);
    return (32'(t) << 12) | (32'(s & 127) << 5) | 32'(o & 31);
  endfunction

  typedef struct packed {
    logic        cv;
    logic [1:0]  cop;
    logic [31:0] ca;
    logic [1:0]  cw;
    logic        cx;
    logic        sv;
    logic        sk;
    logic [31:0] sa;
    logic        e_dn;
    logic        e_rp;
    logic        e_hit;
    logic [1:0]  e_st;
    logic        e_ev;
    logic [31:0] e_eva;
    logic        e_sv;
    logic [1:0]  e_sr;
  } vec_t;

  // A=0x1060 B=0x2060 C=0x3120 D=0x4120 E=0x5280 F=0x6060
  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1'b1, 2'd0, 32'h1067, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,    1'b0, 2'd0}, // R1 empty miss
    '{1'b1, 2'd2, 32'h1060, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,    1'b0, 2'd0}, // R4 fill A excl
    '{1'b1, 2'd0, 32'h107F, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,    1'b0, 2'd0}, // R2 offset ignored
    '{1'b1, 2'd0, 32'h2060, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,    1'b0, 2'd0}, // R2 other tag misses
    '{1'b1, 2'd2, 32'h2060, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,    1'b0, 2'd0}, // R4 fill B shared
    '{1'b1, 2'd1, 32'h2060, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 32'h0,    1'b0, 2'd0}, // R3 write to S
    '{1'b1, 2'd1, 32'h1060, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0,    1'b0, 2'd0}, // R3 write to E
    '{1'b0, 2'd0, 32'h0,    2'd0, 1'b0, 1'b1, 1'b0, 32'h2060, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,    1'b1, 2'd1}, // R5 snoop read S
    '{1'b1, 2'd2, 32'h3120, 2'd2, 1'b1, 1'b1, 1'b1, 32'h2060, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,    1'b1, 2'd2}, // R6 R12
    '{1'b1, 2'd0, 32'h2060, 2'd0, 1'b0, 1'b1, 1'b0, 32'h3120, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,    1'b1, 2'd1}, // R6 B gone, R5 C E->S
    '{1'b1, 2'd0, 32'h3120, 2'd0, 1'b0, 1'b1, 1'b0, 32'h4120, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,    1'b1, 2'd0}, // R5 C shared, snoop miss
    '{1'b1, 2'd2, 32'h4120, 2'd2, 1'b1, 1'b1, 1'b1, 32'h3120, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0,    1'b1, 2'd2}, // R11 fill vs snoop kill
    '{1'b1, 2'd0, 32'h4120, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,    1'b0, 2'd0}, // R11 fill dropped
    '{1'b1, 2'd0, 32'h3120, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,    1'b0, 2'd0}, // R11 snoop applied
    '{1'b1, 2'd2, 32'h5280, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,    1'b0, 2'd0}, // R4 fill E excl
    '{1'b1, 2'd1, 32'h5280, 2'd0, 1'b0, 1'b1, 1'b0, 32'h5280, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0,    1'b1, 2'd1}, // R11 write vs snoop read
    '{1'b1, 2'd0, 32'h5280, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,    1'b0, 2'd0}, // R11 write dropped
    '{1'b1, 2'd2, 32'h6060, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 32'h1060, 1'b0, 2'd0}, // R4 evict M
    '{1'b1, 2'd0, 32'h1060, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,    1'b0, 2'd0}, // R4 A replaced
    '{1'b1, 2'd0, 32'h6060, 2'd0, 1'b0, 1'b1, 1'b1, 32'h1060, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,    1'b1, 2'd0}  // R12 snoop miss + hit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_valid = 1'b0; cpu_op = 2'd0; cpu_addr = '0; cpu_way = '0; cpu_excl = 1'b0;
    snp_valid = 1'b0; snp_kill = 1'b0; snp_addr = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_req(input logic [1:0] op, input logic [31:0] a,
                         input logic [1:0] w, input logic x);
    cpu_valid = 1'b1; cpu_op = op; cpu_addr = a; cpu_way = w; cpu_excl = x;
  endtask

  task automatic snp_req(input logic k, input logic [31:0] a);
    snp_valid = 1'b1; snp_kill = k; snp_addr = a;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    wb_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset outputs
    chk("R1 stall", 32'(cpu_stall), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
    chk("R1 done", 32'(cpu_done), 0);
    chk("R1 snp_resp_valid", 32'(snp_resp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      idle();
      if (VT[i].cv) cpu_req(VT[i].cop, VT[i].ca, VT[i].cw, VT[i].cx);
      if (VT[i].sv) snp_req(VT[i].sk, VT[i].sa);
      cyc();
      chk($sformatf("row%0d done", i),   32'(cpu_done),   32'(VT[i].e_dn));
      chk($sformatf("row%0d replay", i), 32'(cpu_replay), 32'(VT[i].e_rp));
      chk($sformatf("row%0d hit", i),    32'(cpu_hit),    32'(VT[i].e_hit));
      chk($sformatf("row%0d state", i),  32'(cpu_state),  32'(VT[i].e_st));
      chk($sformatf("row%0d evict", i),  32'(cpu_evict),  32'(VT[i].e_ev));
      if (VT[i].e_ev) chk($sformatf("row%0d evict_addr", i), cpu_evict_addr, VT[i].e_eva);
      chk($sformatf("row%0d snp_valid", i), 32'(snp_resp_valid), 32'(VT[i].e_sv));
      if (VT[i].e_sv) chk($sformatf("row%0d snp_resp", i), 32'(snp_resp), 32'(VT[i].e_sr));
    end
    idle();

    // Push-out on snooped read: G = tag 7, set 30
    cpu_req(2'd2, mk(7, 30, 0), 2'd3, 1'b1); cyc(); idle();
    cpu_req(2'd1, mk(7, 30, 4), 2'd0, 1'b0); cyc(); idle();
    chk("R3 write makes M", 32'(cpu_state), 3);

    snp_req(1'b0, mk(7, 30, 8)); cyc(); idle();
    chk("R7 retry", 32'(snp_resp), 3);
    chk("R7 wb_valid", 32'(wb_valid), 1);
    chk("R7 wb_addr", wb_addr, mk(7, 30, 0));
    chk("R10 stall", 32'(cpu_stall), 1);

    cpu_req(2'd0, mk(7, 30, 0), 2'd0, 1'b0);
    snp_req(1'b0, mk(7, 30, 0)); cyc(); idle();
    chk("R10 ignored while stalled", 32'(cpu_done | cpu_replay), 0);
    chk("R9 retried again", 32'(snp_resp), 3);
    chk("R7 wb held", 32'(wb_valid), 1);
    chk("R7 wb_addr held", wb_addr, mk(7, 30, 0));

    wb_ready = 1'b1; cyc(); wb_ready = 1'b0;
    chk("R8 wb drops", 32'(wb_valid), 0);
    chk("R8 stall drops", 32'(cpu_stall), 0);
    cpu_req(2'd0, mk(7, 30, 0), 2'd0, 1'b0); cyc(); idle();
    chk("R8 read snoop leaves S", 32'(cpu_state), 1);

    // Push-out on snooped write: H = tag 8, set 31, ready already high
    cpu_req(2'd2, mk(8, 31, 0), 2'd0, 1'b1); cyc(); idle();
    cpu_req(2'd1, mk(8, 31, 0), 2'd0, 1'b0); cyc(); idle();
    wb_ready = 1'b1;
    snp_req(1'b1, mk(8, 31, 0)); cyc(); idle();
    chk("R7 kill retry", 32'(snp_resp), 3);
    chk("R7 kill wb_addr", wb_addr, mk(8, 31, 0));
    cyc(); wb_ready = 1'b0;
    chk("R8 kill wb drops", 32'(wb_valid), 0);
    cpu_req(2'd0, mk(8, 31, 0), 2'd0, 1'b0); cyc(); idle();
    chk("R8 write snoop leaves I", 32'(cpu_hit), 0);

    // R1 reset clears valid lines
    rst_n = 1'b0; cyc(); rst_n = 1'b1;
    cpu_req(2'd0, mk(6, 3, 0), 2'd0, 1'b0); cyc(); idle();
    chk("R1 miss after reset", 32'(cpu_hit), 0);
    chk("R1 done after reset", 32'(cpu_done), 1);

    finish_run();
  end

endmodule